// File: doc/BRIEF.md
# Programmable Dual-Channel Parallel CRC Engine

The engine computes cyclic redundancy checks with a generator polynomial and degree supplied at run time. The degree can be anything from 1 to 64. Two independent channels each absorb a 16-bit data word per clock. A join input merges them into one channel that absorbs 32 bits per clock, so a wider stream can be checked at the same clock rate.

Each channel keeps a 64-bit remainder register. Only the low `d` bits are meaningful for a polynomial of degree `d`. A load strobe seeds the register with an initial value, and a valid strobe advances it by one data word. The polynomial is given without its implicit x^d term: bit k of the polynomial port is the coefficient of x^k.

The per-clock update is the bit-serial shift-register step, unrolled over the word and taken most significant bit first. The stages are chained, so every result bit draws on the same intermediate remainders. No result bit has its own XOR tree.

Top module: `crc_dual_engine`

## Requirements
- R1: One serial step of a channel with degree d, for input bit b, is defined as: f = crc[d-1] XOR b, then crc = ((crc << 1) XOR (f ? poly : 0)) AND mask. Here mask has its low d bits set. The degree is valid from 1 to 64.
- R2: With `join_mode` = 0, a cycle with `a_valid` = 1 and `a_load` = 0 advances channel A by 16 serial steps over `a_data`, bit 15 first, using `a_poly` and `a_deg`.
- R3: With `join_mode` = 0, a cycle with `b_valid` = 1 and `b_load` = 0 advances channel B by 16 serial steps over `b_data`, bit 15 first, using `b_poly` and `b_deg`.
- R4: With `join_mode` = 1, a cycle with `a_valid` = 1 and `a_load` = 0 advances channel A by 32 serial steps over the word {`a_data`, `b_data`}, bit 31 first, using `a_poly` and `a_deg`. The value of `b_crc` in this mode is unspecified.
- R5: A cycle with the load strobe high sets that channel's register to its initial value AND mask, whatever its valid strobe is.
- R6: A channel whose valid and load strobes are both low holds its register unchanged.
- R7: After reset both result outputs read 0.
- R8: After any load or update, register bits at positions d and above are 0.
- R9: In split mode, activity on one channel leaves the other channel's result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| join_mode | input | 1 | 1 joins both channels into one 32-bit channel A |
| a_data | input | 16 | Channel A data word (upper half when joined) |
| a_valid | input | 1 | Channel A word strobe |
| a_load | input | 1 | Channel A initial-value load |
| a_init | input | 64 | Channel A initial value |
| a_poly | input | 64 | Channel A polynomial, x^d term omitted |
| a_deg | input | 7 | Channel A degree, 1 to 64 |
| a_crc | output | 64 | Channel A remainder |
| b_data | input | 16 | Channel B data word (lower half when joined) |
| b_valid | input | 1 | Channel B word strobe |
| b_load | input | 1 | Channel B initial-value load |
| b_init | input | 64 | Channel B initial value |
| b_poly | input | 64 | Channel B polynomial, x^d term omitted |
| b_deg | input | 7 | Channel B degree, 1 to 64 |
| b_crc | output | 64 | Channel B remainder |

## Verification
The hardest case to reach from the ports is a degree of 1 or 64. At these degrees the feedback tap sits at an end of the register, and a mask or tap-index error changes the result only there. The stimulus therefore runs a parity polynomial of degree 1 on one channel and a 64-bit polynomial on the other.

The same 64-bit polynomial also runs in joined mode, where the word is split across both channels' data ports. Load and valid are raised together in the same cycle to exercise the priority between them. An idle channel is checked while the other is busy, and both results are compared on every cycle against a bit-serial model.

// File: rtl/crc_pkg.sv
package crc_pkg;
    localparam int CRC_W  = 64;
    localparam int LANE_W = 16;
    localparam int DEG_W  = $clog2(CRC_W) + 1;
    localparam int IDX_W  = $clog2(CRC_W);

    typedef logic [CRC_W-1:0] crc_t;

    typedef struct packed {
        crc_t crc;
    } lane_st_t;

    // one serial step; bits above the tap are left dirty and masked by the caller
    function automatic crc_t crc_step(crc_t c, crc_t poly, logic [IDX_W-1:0] msb, logic din);
        logic fb;
        fb = c[msb] ^ din;
        return (c << 1) ^ (fb ? poly : '0);
    endfunction
endpackage

// File: rtl/crc_unroll.sv
module crc_unroll
    import crc_pkg::*;
#(
    parameter int STEPS = 32,
    parameter int TAP   = 16
) (
    input  crc_t                 crc_in,
    input  crc_t                 poly,
    input  logic [IDX_W-1:0]     msb,
    input  logic [STEPS-1:0]     data,
    output crc_t                 crc_tap,
    output crc_t                 crc_full
);
    crc_t chain [0:STEPS];

    assign chain[0] = crc_in;

    // each stage feeds the next, so all result bits share the intermediate remainders
    for (genvar g = 0; g < STEPS; g++) begin : g_stage
        assign chain[g+1] = crc_step(chain[g], poly, msb, data[STEPS-1-g]);
    end

    assign crc_tap  = chain[TAP];
    assign crc_full = chain[STEPS];
endmodule

// File: rtl/crc_lane.sv
module crc_lane
    import crc_pkg::*;
#(
    parameter int STEPS = 16,
    parameter int TAP   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic              load,
    input  logic              use_full,
    input  crc_t              init,
    input  crc_t              poly,
    input  logic [DEG_W-1:0]  deg,
    input  logic [STEPS-1:0]  data,
    output crc_t              crc
);
    lane_st_t         st_d, st_q;
    crc_t             mask;
    logic [IDX_W-1:0] msb;
    crc_t             nxt_tap, nxt_full;

    assign mask = (deg >= DEG_W'(CRC_W)) ? '1 : ((crc_t'(1) << deg) - crc_t'(1));
    assign msb  = deg[IDX_W-1:0] - IDX_W'(1);

    crc_unroll #(.STEPS(STEPS), .TAP(TAP)) u_unroll (
        .crc_in   (st_q.crc),
        .poly     (poly),
        .msb      (msb),
        .data     (data),
        .crc_tap  (nxt_tap),
        .crc_full (nxt_full)
    );

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.crc = init & mask;
        end else if (valid) begin
            st_d.crc = (use_full ? nxt_full : nxt_tap) & mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign crc = st_q.crc;

    always_comb begin
        if (rst_n && (valid || load)) begin
            AST_DEG_RANGE: assert (deg >= DEG_W'(1) && deg <= DEG_W'(CRC_W)) else $error("degree out of range"); // R1
        end
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && !load) |=> $stable(crc)); // R6

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (crc == $past(init & mask))); // R5

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (valid || load) |=> ((crc & ~$past(mask)) == '0)); // R8
endmodule

// File: rtl/crc_dual_engine.sv
module crc_dual_engine
    import crc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              join_mode,
    input  logic [15:0]       a_data,
    input  logic              a_valid,
    input  logic              a_load,
    input  logic [63:0]       a_init,
    input  logic [63:0]       a_poly,
    input  logic [6:0]        a_deg,
    output logic [63:0]       a_crc,
    input  logic [15:0]       b_data,
    input  logic              b_valid,
    input  logic              b_load,
    input  logic [63:0]       b_init,
    input  logic [63:0]       b_poly,
    input  logic [6:0]        b_deg,
    output logic [63:0]       b_crc
);
    localparam int JOIN_W = 2 * LANE_W;

    logic [JOIN_W-1:0] a_word;

    // channel A walks its own word first; in split mode it stops at the half-way tap
    assign a_word = {a_data, b_data};

    crc_lane #(.STEPS(JOIN_W), .TAP(LANE_W)) u_lane_a (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid    (a_valid),
        .load     (a_load),
        .use_full (join_mode),
        .init     (a_init),
        .poly     (a_poly),
        .deg      (a_deg),
        .data     (a_word),
        .crc      (a_crc)
    );

    crc_lane #(.STEPS(LANE_W), .TAP(LANE_W)) u_lane_b (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid    (b_valid),
        .load     (b_load),
        .use_full (1'b0),
        .init     (b_init),
        .poly     (b_poly),
        .deg      (b_deg),
        .data     (b_data),
        .crc      (b_crc)
    );

    AST_B_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!join_mode && !b_valid && !b_load) |=> $stable(b_crc)); // R9
endmodule

// File: tb/crc_dual_engine_test.sv
module crc_dual_engine_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic join_mode = 1'b0;
    logic [15:0] a_data = '0, b_data = '0;
    logic a_valid = 1'b0, a_load = 1'b0, b_valid = 1'b0, b_load = 1'b0;
    logic [63:0] a_init = '0, a_poly = '0, b_init = '0, b_poly = '0;
    logic [6:0] a_deg = 7'd16, b_deg = 7'd16;
    logic [63:0] a_crc, b_crc;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    typedef struct {
        logic [63:0] exp_a;
        logic [63:0] exp_b;
        bit          chk_a;
        bit          chk_b;
        string       tag;
    } item_t;
    item_t sb[$];

    logic [63:0] m_a = '0, m_b = '0;

    always #4 clk = ~clk;

    crc_dual_engine uut (
        .clk(clk), .rst_n(rst_n), .join_mode(join_mode),
        .a_data(a_data), .a_valid(a_valid), .a_load(a_load), .a_init(a_init),
        .a_poly(a_poly), .a_deg(a_deg), .a_crc(a_crc),
        .b_data(b_data), .b_valid(b_valid), .b_load(b_load), .b_init(b_init),
        .b_poly(b_poly), .b_deg(b_deg), .b_crc(b_crc)
    );

    function automatic logic [63:0] mk_mask(int d);
        return (d >= 64) ? '1 : ((64'd1 << d) - 64'd1);
    endfunction

    function automatic logic [63:0] ref_run(logic [63:0] c, logic [63:0] p, int d,
                                            logic [31:0] w, int n);
        logic f;
        for (int i = n - 1; i >= 0; i--) begin
            f = c[d-1] ^ w[i];
            c = ((c << 1) ^ (f ? p : 64'd0)) & mk_mask(d);
        end
        return c;
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // advance the model by the inputs applied now, queue the expectation, wait one cycle
    task automatic tick(string tag, bit ca, bit cb);
        item_t it;
        if (a_load) m_a = a_init & mk_mask(int'(a_deg));
        else if (a_valid)
            m_a = join_mode ? ref_run(m_a, a_poly, int'(a_deg), {a_data, b_data}, 32)
                            : ref_run(m_a, a_poly, int'(a_deg), {16'h0, a_data}, 16);
        if (b_load) m_b = b_init & mk_mask(int'(b_deg));
        else if (b_valid) m_b = ref_run(m_b, b_poly, int'(b_deg), {16'h0, b_data}, 16);
        it.exp_a = m_a; it.exp_b = m_b; it.chk_a = ca; it.chk_b = cb; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            if (it.chk_a) check({it.tag, " chA"}, a_crc, it.exp_a);
            if (it.chk_b) check({it.tag, " chB"}, b_crc, it.exp_b);
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] pat [0:5];
        pat[0] = 16'h0000; pat[1] = 16'hFFFF; pat[2] = 16'h8001;
        pat[3] = 16'hA5C3; pat[4] = 16'h1234; pat[5] = 16'h7F00;

        repeat (2) @(negedge clk);
        check("R7 reset a", a_crc, 64'd0);
        check("R7 reset b", b_crc, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 load with oversize init: result is init masked to degree (R8)
        a_poly = 64'h1021;      a_deg = 7'd16;
        b_poly = 64'h04C11DB7;  b_deg = 7'd32;
        a_init = '1; b_init = '1;
        a_load = 1; b_load = 1;
        tick("R5 R8 load masked", 1, 1);
        a_load = 0; b_load = 0;

        // R2 R3 split mode, both channels together
        for (int i = 0; i < 6; i++) begin
            a_data = pat[i]; b_data = ~pat[5-i];
            a_valid = 1; b_valid = 1;
            tick("R2 R3 split word", 1, 1);
        end

        // R6 hold with data changing
        a_valid = 0; b_valid = 0; a_data = 16'hDEAD; b_data = 16'hBEEF;
        tick("R6 hold", 1, 1);
        tick("R6 hold", 1, 1);

        // R9 channel A busy, B idle
        a_valid = 1;
        for (int i = 0; i < 3; i++) begin
            a_data = pat[i+2];
            tick("R9 B untouched", 1, 1);
        end
        a_load = 1; a_init = 64'h0000_0000_0000_ABCD;
        tick("R9 A load B idle", 1, 1);
        a_load = 0;

        // R5 load wins over valid in same cycle
        a_valid = 1; a_load = 1; a_init = 64'h5555; a_data = 16'hFFFF;
        tick("R5 load priority", 1, 1);
        a_load = 0; a_valid = 0;

        // R1 degree 1 parity on A, degree 64 on B
        a_poly = 64'h1; a_deg = 7'd1; a_init = 64'h1; a_load = 1;
        b_poly = 64'h42F0E1EBA9EA3693; b_deg = 7'd64; b_init = '1; b_load = 1;
        tick("R1 R8 load edge deg", 1, 1);
        a_load = 0; b_load = 0;
        for (int i = 0; i < 5; i++) begin
            a_data = pat[i] ^ 16'h0101; b_data = pat[5-i];
            a_valid = 1; b_valid = 1;
            tick("R1 edge deg word", 1, 1);
        end
        a_valid = 0; b_valid = 0;

        // R1 R8 small degree 5
        a_poly = 64'h05; a_deg = 7'd5; a_init = 64'h1F; a_load = 1;
        tick("R8 deg5 load", 1, 0);
        a_load = 0; a_valid = 1;
        for (int i = 0; i < 3; i++) begin
            a_data = pat[i+3];
            tick("R1 R8 deg5 word", 1, 0);
        end
        a_valid = 0;

        // R4 joined mode, 64-bit polynomial
        join_mode = 1;
        a_poly = 64'h42F0E1EBA9EA3693; a_deg = 7'd64; a_init = '1; a_load = 1;
        tick("R4 join load", 1, 0);
        a_load = 0;
        for (int i = 0; i < 6; i++) begin
            a_data = pat[i]; b_data = pat[(i+3)%6] ^ 16'h3C3C;
            a_valid = 1;
            tick("R4 join 64", 1, 0);
        end
        a_valid = 0;
        tick("R4 R6 join hold", 1, 0);

        // R4 joined mode, 32-bit polynomial
        a_poly = 64'h04C11DB7; a_deg = 7'd32; a_init = 64'hFFFF_FFFF; a_load = 1;
        tick("R4 join load 32", 1, 0);
        a_load = 0;
        for (int i = 0; i < 4; i++) begin
            a_data = pat[i+1]; b_data = pat[i];
            a_valid = 1;
            tick("R4 join 32", 1, 0);
        end
        a_valid = 0;

        // back to split: reload B and run it alone
        join_mode = 0;
        b_poly = 64'h1021; b_deg = 7'd16; b_init = 64'h1D0F; b_load = 1;
        tick("R3 reload", 1, 1);
        b_load = 0; b_valid = 1;
        for (int i = 0; i < 3; i++) begin
            b_data = pat[i+1];
            tick("R3 R9 B alone", 1, 1);
        end
        b_valid = 0;

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule